// File: doc/BRIEF.md
# Registered Sixteen-Function Bitwise Logic Unit

This block applies any one of the sixteen two-input Boolean functions to a pair of N-bit operands. Every bit position is handled on its own. The result goes into an output register. A 4-bit operation code picks the function, and the code is itself the truth table: for each bit, the operand bit pair picks one bit of the code. This means one small multiplexer per bit is enough to cover all sixteen operations.

The register loads on a rising clock edge when the load enable is high. Otherwise it keeps its value. A synchronous reset sets it to zero. A datapath sequencer drives the operands and the code, then pulses the load enable to capture the result.

Top module: `bitfunc_unit`

## Requirements
- R1: When `rst` is high at a rising edge, `res` becomes all zeros, whatever the values of `ld` and the other inputs.
- R2: When `rst` is low and `ld` is high at a rising edge, every bit k of `res` takes `op[3 - 2*opa[k] - opb[k]]`. Truth-table rows go from (a,b)=00 at op bit 3 down to (a,b)=11 at op bit 0.
- R3: When `rst` and `ld` are both low at a rising edge, `res` keeps its value, even if `opa`, `opb` or `op` change.
- R4: Code 0 loads all zeros and code 15 loads all ones, independent of the operands.
- R5: Code 1 loads a AND b, code 7 loads a OR b, and code 6 loads a XOR b.
- R6: Code 14 loads NAND, code 8 loads NOR, and code 9 loads XNOR.
- R7: Code 3 loads `opa` and code 5 loads `opb`. Code 12 loads NOT `opa` and code 10 loads NOT `opb`.
- R8: Code 2 loads a AND NOT b and code 4 loads NOT a AND b. Code 11 loads a OR NOT b and code 13 loads NOT a OR b.
- R9: The function is applied to each bit independently, so a bit's result depends only on that bit's operands and the code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld | input | 1 | Load enable for the result register |
| op | input | 4 | Function code (truth-table column) |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| res | output | WIDTH | Result register |

## Verification
The case that is hardest to reach from the ports is one where all four operand-bit pairs are present in the same word. Only then does a single load exercise every bit of the code at once, and only then is a crossed bit index visible. The bench sets the width to 4 and loads every code with every pair of operands. Every word of that sweep is then repeated while the load enable is low, to confirm that the register holds.

// File: rtl/bitfunc_unit.sv
module bitfunc_unit #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] res
);
  logic [WIDTH-1:0] nxt;

  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    logic [1:0] row;
    assign row    = 2'd3 - {opa[k], opb[k]};
    assign nxt[k] = op[row];
  end

  always_ff @(posedge clk) begin
    if (rst)     res <= '0;
    else if (ld) res <= nxt;
  end
endmodule

// File: rtl/bitfunc_unit_chk.sv
module bitfunc_unit_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ld,
  input logic [3:0]       op,
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [WIDTH-1:0] res
);
  logic started;
  always_ff @(posedge clk) started <= 1'b1;

  p_reset_clears_r1: assert property (@(posedge clk) disable iff (!started)
    rst |=> (res == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst || !started)
    !ld |=> $stable(res));

  p_const_r4: assert property (@(posedge clk) disable iff (rst || !started)
    (ld && (op == 4'd0 || op == 4'd15)) |=> ($countones(res) == ($past(op) == 4'd15 ? WIDTH : 0)));

  p_and_or_r5: assert property (@(posedge clk) disable iff (rst || !started)
    (ld && op == 4'd1) |=> (res == ($past(opa) & $past(opb))));

  p_xor_r5: assert property (@(posedge clk) disable iff (rst || !started)
    (ld && op == 4'd6) |=> (res == ($past(opa) ^ $past(opb))));

  p_nand_r6: assert property (@(posedge clk) disable iff (rst || !started)
    (ld && op == 4'd14) |=> (res == ~($past(opa) & $past(opb))));

  p_pass_a_r7: assert property (@(posedge clk) disable iff (rst || !started)
    (ld && op == 4'd3) |=> (res == $past(opa)));
endmodule

bind bitfunc_unit bitfunc_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .ld(ld), .op(op), .opa(opa), .opb(opb), .res(res)
);

// File: tb/bitfunc_unit_bench.sv
module bitfunc_unit_bench;
  localparam int W = 4;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst, ld;
  logic [3:0] op;
  logic [W-1:0] opa, opb, res;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  bitfunc_unit #(.WIDTH(W)) u_bitfunc_unit (
    .clk(clk), .rst(rst), .ld(ld), .op(op), .opa(opa), .opb(opb), .res(res)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] model(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    case (c)
      4'd0:  r = '0;
      4'd1:  r = a & b;
      4'd2:  r = a & ~b;
      4'd3:  r = a;
      4'd4:  r = ~a & b;
      4'd5:  r = b;
      4'd6:  r = a ^ b;
      4'd7:  r = a | b;
      4'd8:  r = ~(a | b);
      4'd9:  r = ~(a ^ b);
      4'd10: r = ~b;
      4'd11: r = a | ~b;
      4'd12: r = ~a;
      4'd13: r = ~a | b;
      4'd14: r = ~(a & b);
      default: r = '1;
    endcase
    return r;
  endfunction

  function automatic string tag(input logic [3:0] c);
    case (c)
      4'd0, 4'd15: return "R4";
      4'd1, 4'd6, 4'd7: return "R5";
      4'd8, 4'd9, 4'd14: return "R6";
      4'd3, 4'd5, 4'd10, 4'd12: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] exp);
    n_run++;
    if (res !== exp) begin
      n_fail++;
      $display("FAIL %s: res=%h expected=%h", req, res, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  initial begin
    rst = 1'b1; ld = 1'b1; op = 4'd15; opa = '1; opb = '1;
    #(CLK_PERIOD/4);
    cyc();
    check("R1", '0);
    rst = 1'b0; ld = 1'b1; op = 4'd15;
    cyc();
    check("R4", '1);
    rst = 1'b1; ld = 1'b0;
    cyc();
    check("R1", '0);
    rst = 1'b0;
    // R2, R9: one word holding all four bit pairs checks every code bit at once
    ld = 1'b1; opa = 4'b1100; opb = 4'b1010;
    for (int c = 0; c < 16; c++) begin
      op = c[3:0];
      cyc();
      check("R2", {op[0], op[1], op[2], op[3]});
    end
    // full sweep: load every code and operand pair, then hold with a changed input
    for (int c = 0; c < 16; c++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          logic [W-1:0] e;
          ld = 1'b1; op = c[3:0]; opa = a[W-1:0]; opb = b[W-1:0];
          e = model(op, opa, opb);
          cyc();
          check(tag(op), e);
          ld = 1'b0; op = ~op; opa = ~opa; opb = opb + 4'd1;
          cyc();
          check("R3", e);
        end
      end
    end
    // R9: flipping one bit's operands changes only that bit
    ld = 1'b1; op = 4'd6; opa = 4'b0000; opb = 4'b0100;
    cyc();
    check("R9", 4'b0100);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: res=%h expected=done", res);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule